// File: doc/BRIEF.md
# Security-Banked System Exception Priority Block

This block stores the 8-bit priority levels of the configurable system exceptions in a processor interrupt controller. It sits on a register bus as a window of three 32-bit words. Each byte of the window holds the priority of one exception, and the exception number is the byte offset minus 0xD14. Exceptions that have separate secure and non-secure handlers keep two copies of their priority. The others keep one shared copy. Some of those shared copies are hidden from non-secure software. Every access carries a security flag. For each byte lane separately, the block decides whether the lane reaches the secure copy, reaches the shared copy, or reads as zero and ignores writes.

Both copies of every priority are driven onto flat output vectors for the downstream prioritisation logic. A one-cycle change strobe tells that logic when to recompute. Reads are combinational. Writes take effect at the clock edge.

Top module: `sysprio_bank`

## Requirements
- R1: The window spans offsets 0xD18 to 0xD23. Data byte i of an access (bits 8i+7:8i) addresses offset `acc_addr`+i, which holds the priority of exception number (`acc_addr`+i−0xD14). Offset 0xD18 is therefore exception 4.
- R2: Exceptions 4, 6, 11, 14 and 15 are banked. An access with `acc_sec`=1 reads and writes the secure copy. An access with `acc_sec`=0 uses the non-secure copy. The two copies never affect each other.
- R3: Exception 5 reads as zero and ignores writes when `acc_sec`=0 and `bf_ns_en`=0. In every other case it uses its single shared copy.
- R4: Exception 7 reads as zero and ignores writes for any access with `acc_sec`=0. Accesses with `acc_sec`=1 reach its shared copy.
- R5: Exception 12 is reachable through its shared copy from either security state.
- R6: Exceptions 8, 9, 10 and 13 always read as zero and ignore writes.
- R7: `acc_size` sets the number of lanes: 0 gives one byte, 1 gives two, 2 gives four, and 3 gives none. Inactive or blocked lanes read zero and store nothing, and they do not disturb the other lanes.
- R8: After reset, every priority in both banks is zero.
- R9: `prio_chg` is 1 for exactly the cycle after a clock edge at which a write changed the value of at least one stored priority. Otherwise it is 0, including after writes that store an identical value.
- R10: A byte whose offset falls outside the window reads as zero and has no effect on any stored value.
- R11: Byte k of `ns_prio_o` is the shared or non-secure priority of exception 4+k. Byte k of `s_prio_o` is the secure priority of exception 4+k when that exception is banked, and zero when it is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_addr | input | 12 | Byte offset of the access |
| acc_size | input | 2 | Lane count code (0:1, 1:2, 2:4, 3:none) |
| acc_wdata | input | 32 | Write data, byte i for offset acc_addr+i |
| acc_wr | input | 1 | Write enable, sampled at the clock edge |
| acc_sec | input | 1 | Security flag of the access (1 = secure) |
| bf_ns_en | input | 1 | Lets non-secure accesses reach exception 5 |
| acc_rdata | output | 32 | Combinational read data |
| ns_prio_o | output | 96 | Shared/non-secure priorities, exceptions 4..15 |
| s_prio_o | output | 96 | Secure priorities, exceptions 4..15 |
| prio_chg | output | 1 | Change strobe, one cycle after a changing write |

## Verification
Properties checked on every cycle:
- A non-secure write leaves the whole secure bank stable.
- Exception 7, and exception 5 while `bf_ns_en` is clear, stay stable under non-secure writes.
- A write that lies entirely outside the window changes nothing.
- Each stored field moves only when it is write-enabled.
- The change strobe appears only after a write.

Only the scoreboard scenarios can show the rest:
- The exact lane-to-exception mapping, including unaligned and partial accesses.
- The read-as-zero values.
- The strobe staying low on writes that store an identical value.
- The agreement of both output vectors with the bank model.

// File: rtl/sysprio_pkg.sv
package sysprio_pkg;

   typedef enum logic [1:0] {
      RT_NONE   = 2'd0,
      RT_SHARED = 2'd1,
      RT_SECURE = 2'd2
   } route_e;

   // Exceptions that keep a separate secure copy: 4, 6, 11, 14, 15
   localparam logic [15:0] BANKED_SET = 16'hC850;
   // Non-banked exceptions reachable from either security state: 12
   localparam logic [15:0] OPEN_SET   = 16'h1000;
   localparam logic [3:0]  EXC_BUSF   = 4'd5;
   localparam logic [3:0]  EXC_SECF   = 4'd7;

   // Which copy (if any) one byte lane reaches.
   function automatic route_e route_of(input int unsigned exc,
                                       input logic sec,
                                       input logic bf_en);
      route_e     r;
      logic [3:0] e;
      r = RT_NONE;
      e = exc[3:0];
      if (exc < 16) begin
         if (BANKED_SET[e])
            r = sec ? RT_SECURE : RT_SHARED;
         else if (e == EXC_BUSF)
            r = (sec || bf_en) ? RT_SHARED : RT_NONE;
         else if (e == EXC_SECF)
            r = sec ? RT_SHARED : RT_NONE;
         else if (OPEN_SET[e])
            r = RT_SHARED;
      end
      return r;
   endfunction

endpackage

// File: rtl/sysprio_field.sv
module sysprio_field #(
   parameter int unsigned W       = 8,
   parameter bit          PRESENT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (PRESENT) begin : g_reg
         logic [W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  r <= '0;
            else if (we) r <= d;
         end
         assign q = r;

         // R7: a field no lane reaches keeps its value
         p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !we |=> $stable(q));
      end else begin : g_tie
         logic unused_in;
         assign unused_in = ^{clk, rst_n, we, d};
         assign q = '0;
      end
   endgenerate

endmodule

// File: rtl/sysprio_lane_route.sv
module sysprio_lane_route
   import sysprio_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned BASE_OFF  = 'hD18,
   parameter int unsigned NFIELDS   = 12,
   parameter int unsigned FIRST_EXC = 4,
   parameter int unsigned LANE      = 0,
   parameter int unsigned IDX_W     = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              lane_on,
   input  logic              sec,
   input  logic              bf_ns_en,
   output route_e            route,
   output logic [IDX_W-1:0]  idx
);

   localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE_OFF);
   localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE_OFF + NFIELDS);

   logic [ADDR_W:0] baddr;
   logic [ADDR_W:0] off;
   logic            in_win;

   always_comb begin
      baddr  = {1'b0, addr} + (ADDR_W+1)'(LANE);
      in_win = (baddr >= LO) && (baddr < HI);
      off    = baddr - LO;
      idx    = off[IDX_W-1:0];
      route  = RT_NONE;
      if (lane_on && in_win)
         route = route_of(FIRST_EXC + 32'(off), sec, bf_ns_en);
   end

endmodule

// File: rtl/sysprio_bank.sv
module sysprio_bank
   import sysprio_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned BASE_OFF  = 'hD18,
   parameter int unsigned NWORDS    = 3,
   parameter int unsigned FIRST_EXC = 4,
   parameter int unsigned PRIO_W    = 8
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [ADDR_W-1:0]                    acc_addr,
   input  logic [1:0]                           acc_size,
   input  logic [DATA_W-1:0]                    acc_wdata,
   input  logic                                 acc_wr,
   input  logic                                 acc_sec,
   input  logic                                 bf_ns_en,
   output logic [DATA_W-1:0]                    acc_rdata,
   output logic [NWORDS*(DATA_W/8)*PRIO_W-1:0]  ns_prio_o,
   output logic [NWORDS*(DATA_W/8)*PRIO_W-1:0]  s_prio_o,
   output logic                                 prio_chg
);

   localparam int unsigned NLANES  = DATA_W / 8;
   localparam int unsigned NFIELDS = NWORDS * NLANES;
   localparam int unsigned IDX_W   = (NFIELDS > 1) ? $clog2(NFIELDS) : 1;
   localparam int unsigned LAST    = BASE_OFF + NFIELDS - 1;

   // ---------------- elaboration checks ----------------
   generate
      if (PRIO_W != 8) begin : g_bad_prio
         $error("sysprio_bank: each field must be one byte wide");
      end
      if ((DATA_W % 8) != 0 || NLANES < 1 || NLANES > 4) begin : g_bad_data
         $error("sysprio_bank: DATA_W must be 8, 16, 24 or 32");
      end
      if (FIRST_EXC + NFIELDS > 16) begin : g_bad_span
         $error("sysprio_bank: window exceeds the system exception range");
      end
      if (BASE_OFF + NFIELDS > (1 << ADDR_W)) begin : g_bad_addr
         $error("sysprio_bank: window does not fit the address width");
      end
   endgenerate

   // ---------------- lane decode ----------------
   int unsigned           nbytes;
   logic [NLANES-1:0]     lane_on;
   route_e                l_rt  [NLANES];
   logic [IDX_W-1:0]      l_idx [NLANES];

   always_comb begin
      case (acc_size)
         2'd0:    nbytes = 1;
         2'd1:    nbytes = 2;
         2'd2:    nbytes = 4;
         default: nbytes = 0;
      endcase
      for (int i = 0; i < NLANES; i++)
         lane_on[i] = (32'(i) < nbytes);
   end

   generate
      for (genvar g = 0; g < NLANES; g++) begin : g_lane
         sysprio_lane_route #(
            .ADDR_W   (ADDR_W),
            .BASE_OFF (BASE_OFF),
            .NFIELDS  (NFIELDS),
            .FIRST_EXC(FIRST_EXC),
            .LANE     (g),
            .IDX_W    (IDX_W)
         ) u_route (
            .addr     (acc_addr),
            .lane_on  (lane_on[g]),
            .sec      (acc_sec),
            .bf_ns_en (bf_ns_en),
            .route    (l_rt[g]),
            .idx      (l_idx[g])
         );
      end
   endgenerate

   // ---------------- storage ----------------
   logic [PRIO_W-1:0] ns_q [NFIELDS];
   logic [PRIO_W-1:0] s_q  [NFIELDS];
   logic [PRIO_W-1:0] ns_d [NFIELDS];
   logic [PRIO_W-1:0] s_d  [NFIELDS];
   logic [NFIELDS-1:0] ns_we;
   logic [NFIELDS-1:0] s_we;

   generate
      for (genvar f = 0; f < NFIELDS; f++) begin : g_fld
         sysprio_field #(.W(PRIO_W), .PRESENT(1'b1)) u_ns (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (ns_we[f]),
            .d    (ns_d[f]),
            .q    (ns_q[f])
         );
         // secure copy exists only for banked exceptions
         sysprio_field #(.W(PRIO_W), .PRESENT(BANKED_SET[FIRST_EXC + f])) u_s (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (s_we[f]),
            .d    (s_d[f]),
            .q    (s_q[f])
         );
         assign ns_prio_o[f*PRIO_W +: PRIO_W] = ns_q[f];
         assign s_prio_o [f*PRIO_W +: PRIO_W] = s_q[f];
      end
   endgenerate

   // ---------------- read mux and write steering ----------------
   logic chg;

   always_comb begin
      acc_rdata = '0;
      ns_we     = '0;
      s_we      = '0;
      for (int f = 0; f < NFIELDS; f++) begin
         ns_d[f] = ns_q[f];
         s_d[f]  = s_q[f];
      end
      for (int i = 0; i < NLANES; i++) begin
         case (l_rt[i])
            RT_SHARED: begin
               acc_rdata[i*8 +: 8] = ns_q[l_idx[i]];
               if (acc_wr) begin
                  ns_we[l_idx[i]] = 1'b1;
                  ns_d[l_idx[i]]  = acc_wdata[i*8 +: 8];
               end
            end
            RT_SECURE: begin
               acc_rdata[i*8 +: 8] = s_q[l_idx[i]];
               if (acc_wr) begin
                  s_we[l_idx[i]] = 1'b1;
                  s_d[l_idx[i]]  = acc_wdata[i*8 +: 8];
               end
            end
            default: ;
         endcase
      end
      chg = 1'b0;
      for (int f = 0; f < NFIELDS; f++) begin
         if (ns_we[f] && (ns_d[f] != ns_q[f])) chg = 1'b1;
         if (s_we[f]  && (s_d[f]  != s_q[f]))  chg = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prio_chg <= 1'b0;
      else        prio_chg <= chg;
   end

   // ---------------- assertions ----------------
   logic out_of_win;
   assign out_of_win = (32'(acc_addr) > LAST) ||
                       (32'(acc_addr) + NLANES - 1 < BASE_OFF);

   // R2: non-secure writes never reach the secure bank
   p_ns_keeps_sec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_wr && !acc_sec |=> $stable(s_prio_o));

   // R10: a write lying wholly outside the window has no effect
   p_outside_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      acc_wr && out_of_win |=> $stable(ns_prio_o) && $stable(s_prio_o));

   // R9: strobe only follows a write
   p_strobe_after_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      prio_chg |-> $past(acc_wr));

   p_no_strobe_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_wr |=> !prio_chg);

   generate
      if (FIRST_EXC <= 7 && 7 < FIRST_EXC + NFIELDS) begin : g_chk7
         // R4: exception 7 is hidden from non-secure writes
         p_exc7_ns_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
            acc_wr && !acc_sec |=>
               $stable(ns_prio_o[(7-FIRST_EXC)*PRIO_W +: PRIO_W]));
      end
      if (FIRST_EXC <= 5 && 5 < FIRST_EXC + NFIELDS) begin : g_chk5
         // R3: exception 5 is hidden from non-secure writes unless enabled
         p_exc5_ns_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
            acc_wr && !acc_sec && !bf_ns_en |=>
               $stable(ns_prio_o[(5-FIRST_EXC)*PRIO_W +: PRIO_W]));
      end
   endgenerate

endmodule

// File: tb/sim_sysprio_bank.sv
`timescale 1ns/1ps
module sim_sysprio_bank;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [11:0] acc_addr;
   logic [1:0]  acc_size;
   logic [31:0] acc_wdata;
   logic        acc_wr;
   logic        acc_sec;
   logic        bf_ns_en;
   logic [31:0] acc_rdata;
   logic [95:0] ns_prio_o;
   logic [95:0] s_prio_o;
   logic        prio_chg;

   always #2.5 clk = ~clk;

   sysprio_bank u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_addr (acc_addr),
      .acc_size (acc_size),
      .acc_wdata(acc_wdata),
      .acc_wr   (acc_wr),
      .acc_sec  (acc_sec),
      .bf_ns_en (bf_ns_en),
      .acc_rdata(acc_rdata),
      .ns_prio_o(ns_prio_o),
      .s_prio_o (s_prio_o),
      .prio_chg (prio_chg)
   );

   int nvec = 0;
   int nbad = 0;

   logic [7:0] m_ns [12];
   logic [7:0] m_s  [12];

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb[$];
   event  chk_ev;

   task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // 0 = read-as-zero, 1 = shared/non-secure copy, 2 = secure copy
   function automatic int lane_target(int exc, bit sec, bit bfen);
      if (exc == 4 || exc == 6 || exc == 11 || exc == 14 || exc == 15)
         return sec ? 2 : 1;
      if (exc == 5)  return (sec || bfen) ? 1 : 0;
      if (exc == 7)  return sec ? 1 : 0;
      if (exc == 12) return 1;
      return 0;
   endfunction

   // monitor: compares the read data against the scoreboard queue
   initial begin
      forever begin
         @(chk_ev);
         while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            chk(it.tag, {96'b0, acc_rdata}, {96'b0, it.exp});
         end
      end
   end

   task automatic access(input int addr, input int size, input logic [31:0] wd,
                         input bit wr, input bit sec, input string tag);
      int          n;
      logic [31:0] exp;
      bit          changed;
      logic [95:0] e_ns, e_s;
      item_t       it;
      @(negedge clk);
      acc_addr  = 12'(addr);
      acc_size  = 2'(size);
      acc_wdata = wd;
      acc_wr    = wr;
      acc_sec   = sec;
      #1;
      n = (size == 0) ? 1 : (size == 1) ? 2 : (size == 2) ? 4 : 0;
      exp = '0;
      changed = 1'b0;
      for (int i = 0; i < n; i++) begin
         int a;
         int f;
         int t;
         logic [7:0] b;
         a = addr + i;
         if (a >= 'hD18 && a <= 'hD23) begin
            f = a - 'hD18;
            t = lane_target(a - 'hD14, sec, bf_ns_en);
            b = wd[i*8 +: 8];
            if (t == 1) begin
               exp[i*8 +: 8] = m_ns[f];
               if (wr) begin
                  if (m_ns[f] != b) changed = 1'b1;
                  m_ns[f] = b;
               end
            end else if (t == 2) begin
               exp[i*8 +: 8] = m_s[f];
               if (wr) begin
                  if (m_s[f] != b) changed = 1'b1;
                  m_s[f] = b;
               end
            end
         end
      end
      it.exp = exp;
      it.tag = {tag, " read"};
      sb.push_back(it);
      -> chk_ev;
      @(negedge clk);
      acc_wr = 1'b0;
      chk({"R9 strobe ", tag}, {127'b0, prio_chg}, {127'b0, changed});
      for (int f = 0; f < 12; f++) begin
         e_ns[f*8 +: 8] = m_ns[f];
         e_s[f*8 +: 8]  = m_s[f];
      end
      chk({"R11 ns vector ", tag}, {32'b0, ns_prio_o}, {32'b0, e_ns});
      chk({"R11 s vector ", tag},  {32'b0, s_prio_o},  {32'b0, e_s});
   endtask

   initial begin
      #(200000 * 5);
      nbad++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      for (int f = 0; f < 12; f++) begin
         m_ns[f] = '0;
         m_s[f]  = '0;
      end
      rst_n = 1'b0; acc_addr = '0; acc_size = '0; acc_wdata = '0;
      acc_wr = 1'b0; acc_sec = 1'b0; bf_ns_en = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R8: all zero after reset, seen from both security states
      for (int w = 0; w < 3; w++) begin
         access('hD18 + 4*w, 2, 32'h0, 0, 1, "R8 reset sec");
         access('hD18 + 4*w, 2, 32'h0, 0, 0, "R8 reset ns");
      end

      // R1 R2 R3 R4: secure word write to exceptions 4..7
      access('hD18, 2, 32'h11223344, 1, 1, "R1 R2 sec word0");
      access('hD18, 2, 32'h0, 0, 1, "R2 sec readback word0");
      // non-secure, bf_ns_en clear: 5 and 7 blocked
      access('hD18, 2, 32'hAABBCCDD, 1, 0, "R3 R4 ns word0 locked");
      access('hD18, 2, 32'h0, 0, 0, "R2 ns readback word0");
      access('hD18, 2, 32'h0, 0, 1, "R2 sec copy intact");
      // R3: enable bit opens exception 5 to non-secure
      bf_ns_en = 1'b1;
      access('hD19, 0, 32'h00000077, 1, 0, "R3 ns exc5 enabled");
      access('hD18, 2, 32'h0, 0, 0, "R3 ns read enabled");
      bf_ns_en = 1'b0;
      access('hD18, 2, 32'h0, 0, 0, "R3 ns read disabled");

      // R6 R2: word1 = reserved 8,9,10 and banked 11
      access('hD1C, 2, 32'h5A6B7C8D, 1, 1, "R6 sec word1");
      access('hD1C, 2, 32'h01020304, 1, 0, "R6 ns word1");
      access('hD1C, 2, 32'h0, 0, 1, "R6 sec read word1");
      access('hD1C, 2, 32'h0, 0, 0, "R6 ns read word1");

      // R5 R6 R2: word2 = 12, reserved 13, banked 14, 15
      access('hD20, 2, 32'hF0E0D0C0, 1, 0, "R5 ns word2");
      access('hD20, 2, 32'h1F2E3D4C, 1, 1, "R5 sec word2");
      access('hD20, 2, 32'h0, 0, 0, "R5 ns read word2");
      access('hD20, 2, 32'h0, 0, 1, "R5 sec read word2");

      // R7: byte, halfword and unaligned crossing accesses, size 3
      access('hD22, 0, 32'h00000099, 1, 0, "R7 byte exc14 ns");
      access('hD1B, 1, 32'h0000ABCD, 1, 1, "R7 half across words");
      access('hD1A, 1, 32'h0, 0, 0, "R7 half ns read");
      access('hD18, 3, 32'hFFFFFFFF, 1, 1, "R7 size3 none");
      access('hD18, 2, 32'h0, 0, 1, "R7 after size3");

      // R10: outside the window
      access('hD14, 2, 32'hFFFFFFFF, 1, 1, "R10 below window");
      access('hD24, 2, 32'hFFFFFFFF, 1, 1, "R10 above window");
      access('hD22, 2, 32'h0, 0, 1, "R10 straddle read");
      access('hD22, 2, 32'h12345678, 1, 1, "R10 straddle write");

      // R9: identical rewrite gives no strobe; strobe lasts one cycle
      access('hD20, 2, 32'h0, 0, 0, "R9 fetch");
      access('hD18, 0, {24'h0, m_ns[0]}, 1, 0, "R9 same value");
      access('hD18, 0, {24'h0, ~m_ns[0]}, 1, 0, "R9 new value");
      @(negedge clk);
      chk("R9 strobe one cycle", {127'b0, prio_chg}, 128'b0);

      // mixed patterns over all requirements
      for (int k = 0; k < 400; k++) begin
         bf_ns_en = 1'($urandom_range(0, 1));
         access('hD12 + int'($urandom_range(0, 21)), int'($urandom_range(0, 3)),
                $urandom, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                "R1 R2 R3 R4 R5 R6 R7 R10 mixed");
      end

      #1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

endmodule